// File: doc/BRIEF.md
# Packed Shader Uniform Write Assembler

This block sits behind a register write port and builds four-component shader constants out of a stream of 32-bit words. Each of two lanes has its own setup register and its own run of eight data addresses. Lane 0 serves the vertex stage and lane 1 serves the geometry stage. The setup register holds a format bit and a destination index. Every word written to any data address of a lane joins that lane's staging buffer.

When a vector is complete, the lane converts or unpacks the words into four 24-bit float components (x, y, z, w). It stores them in the lane's 96-entry uniform memory at the current index and then advances the index by one. An index of 96 or higher does not write memory. The lane raises an error pulse instead and keeps the index where it is. A combinational read port returns any stored entry.

Each lane is a four-state word counter. The states are `S_EMPTY`, `S_ONE`, `S_TWO` and `S_THREE`, named after how many words are held. The transitions are:
- A data write moves `S_EMPTY` to `S_ONE` and `S_ONE` to `S_TWO`.
- In float mode, a data write moves `S_TWO` to `S_THREE`.
- In packed mode, a data write in `S_TWO` commits the vector and returns to `S_EMPTY`.
- A data write in `S_THREE` commits the vector and returns to `S_EMPTY`.
- A setup write returns any state to `S_EMPTY`.

Top module: `uniform_assembler`

## Requirements
- R1: In float mode (setup bit 31 = 1), a vector is committed on the fourth data word and never on the first three.
- R2: In packed mode (setup bit 31 = 0), a vector is committed on the third data word and never on the first two.
- R3: In packed mode, the three words w0, w1, w2 are unpacked as follows, and the read port presents {w,z,y,x} with w in bits 95:72 and x in bits 23:0:
  - w = w0[31:8]
  - z = {w0[7:0], w1[31:16]}
  - y = {w1[15:0], w2[31:24]}
  - x = w2[23:0]
- R4: In float mode, the first word becomes w, the second z, the third y and the fourth x.
- R5: The float conversion keeps the sign bit. The exponent is re-biased from 127 to 63 into 7 bits. The top 16 mantissa bits are kept and the rest are dropped (truncation).
- R6: When the input exponent field is 64 or less, the result is a signed zero. When it is 191 or more, the result is a signed infinity (exponent 0x7F, mantissa 0).
- R7: The word counter returns to empty on every completed vector, whether the commit was accepted or rejected.
- R8: A completed vector whose index is 96 or higher does not write memory. It pulses `range_err_o` for that lane instead of `commit_o`.
- R9: The index advances by one after an accepted commit and stays the same after a rejected one.
- R10: The eight data addresses of a lane (offsets 8 to 15) behave identically.
- R11: The two lanes have independent counters, buffers, indices and memories. Address bit 4 selects the lane, and offset 0 is the setup register (index in bits 6:0).
- R12: A setup write discards any partially assembled vector.
- R13: After reset, no strobe is active, the mode is packed and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Bit 4 lane, bits 3:0 register offset |
| bus_wdata | input | 32 | Write data |
| rd_lane | input | 1 | Lane selected for read |
| rd_idx | input | 7 | Uniform entry to read |
| rd_vec | output | 96 | Stored vector {w,z,y,x}, zero when out of range |
| commit_o | output | 2 | One-cycle pulse per lane on an accepted commit |
| range_err_o | output | 2 | One-cycle pulse per lane on a rejected commit |

## Verification
On every cycle, the assertions check the following:
- Commit and error never pulse together.
- An error pulse only occurs with an out-of-range index.
- The index steps by exactly one after a commit and holds after an error.
- The counter is empty after either pulse.
- A packed commit follows the two-word state.
- Memory is never written out of range.

Only the bench scenarios can show the data path itself:
- The bit layout of packed unpacking and the reversed component order.
- The exponent re-bias and its saturation limits.
- Aliasing across the eight addresses, the discard on a setup write, and lane independence.

// File: rtl/uniform_asm_pkg.sv
package uniform_asm_pkg;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_ONE   = 2'd1,
        S_TWO   = 2'd2,
        S_THREE = 2'd3
    } fill_state_e;

    localparam int COMP_W   = 24;
    localparam int VEC_W    = 4 * COMP_W;
    localparam int WORD_W   = 32;
    localparam logic [7:0] EXP_LOW  = 8'd64;   // at or below: flush to zero
    localparam logic [7:0] EXP_HIGH = 8'd191;  // at or above: saturate

    function automatic logic [COMP_W-1:0] f32_to_f24(input logic [WORD_W-1:0] v);
        logic [7:0] e;
        logic [7:0] r;
        e = v[30:23];
        r = e - EXP_LOW;
        if (e <= EXP_LOW)
            return {v[31], 23'd0};
        else if (e >= EXP_HIGH)
            return {v[31], 7'h7F, 16'd0};
        else
            return {v[31], r[6:0], v[22:7]};
    endfunction

endpackage

// File: rtl/uniform_store.sv
module uniform_store #(
    parameter int DEPTH = 96,
    parameter int IDX_W = 7,
    parameter int DW    = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wvec,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (32'(widx) < DEPTH))
            mem[widx] <= wvec;
    end

    always_comb begin
        if (32'(ridx) < DEPTH)
            rdata = mem[ridx];
        else
            rdata = '0;
    end

    assert_store_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(widx) < DEPTH));

endmodule

// File: rtl/uniform_lane.sv
module uniform_lane
    import uniform_asm_pkg::*;
#(
    parameter int DEPTH = 96,
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_we,
    input  logic              data_we,
    input  logic [WORD_W-1:0] wdata,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [VEC_W-1:0]  mem_vec,
    output logic              commit_o,
    output logic              err_o
);
    fill_state_e       state_q, state_d;
    logic [WORD_W-1:0] buf0_q, buf1_q, buf2_q;
    logic              fmode_q;
    logic [IDX_W-1:0]  idx_q;
    logic              fire, in_range;

    assign in_range = 32'(idx_q) < DEPTH;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (setup_we) begin
            state_d = S_EMPTY;
        end else if (data_we) begin
            unique case (state_q)
                S_EMPTY: state_d = S_ONE;
                S_ONE:   state_d = S_TWO;
                S_TWO: begin
                    if (fmode_q) begin
                        state_d = S_THREE;
                    end else begin
                        state_d = S_EMPTY;
                        fire    = 1'b1;
                    end
                end
                S_THREE: begin
                    state_d = S_EMPTY;
                    fire    = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        if (fmode_q)
            mem_vec = {f32_to_f24(buf0_q), f32_to_f24(buf1_q),
                       f32_to_f24(buf2_q), f32_to_f24(wdata)};
        else
            mem_vec = {buf0_q, buf1_q, wdata};
    end

    assign mem_we  = fire && in_range;
    assign mem_idx = idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_EMPTY;
        else
            state_q <= state_d;
    end

    // outputs, staging and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf0_q   <= '0;
            buf1_q   <= '0;
            buf2_q   <= '0;
            fmode_q  <= 1'b0;
            idx_q    <= '0;
            commit_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            commit_o <= fire && in_range;
            err_o    <= fire && !in_range;
            if (setup_we) begin
                fmode_q <= wdata[31];
                idx_q   <= wdata[IDX_W-1:0];
            end else if (fire && in_range) begin
                idx_q <= idx_q + 1'b1;
            end
            if (data_we) begin
                unique case (state_q)
                    S_EMPTY: buf0_q <= wdata;
                    S_ONE:   buf1_q <= wdata;
                    S_TWO:   buf2_q <= wdata;
                    S_THREE: ;
                endcase
            end
        end
    end

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && err_o));
    assert_err_out_of_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (32'(idx_q) >= DEPTH));
    assert_index_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (idx_q == $past(idx_q) + 1'b1));
    assert_index_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(idx_q));
    assert_counter_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || err_o) |-> (state_q == S_EMPTY));
    assert_packed_after_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !fmode_q) |-> ($past(state_q) == S_TWO));

endmodule

// File: rtl/uniform_assembler.sv
module uniform_assembler
    import uniform_asm_pkg::*;
#(
    parameter int DEPTH = 96,
    parameter int LANES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        rd_lane,
    input  logic [6:0]  rd_idx,
    output logic [95:0] rd_vec,
    output logic [1:0]  commit_o,
    output logic [1:0]  range_err_o
);
    localparam int IDX_W = $clog2(DEPTH + 1);

    logic [VEC_W-1:0] lane_rdata [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic             sel, setup_we, data_we, mem_we;
        logic [IDX_W-1:0] mem_idx;
        logic [VEC_W-1:0] mem_vec;

        assign sel      = bus_we && (32'(bus_addr[4]) == g);
        assign setup_we = sel && (bus_addr[3:0] == 4'd0);
        assign data_we  = sel && bus_addr[3];

        uniform_lane #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .setup_we (setup_we),
            .data_we  (data_we),
            .wdata    (bus_wdata),
            .mem_we   (mem_we),
            .mem_idx  (mem_idx),
            .mem_vec  (mem_vec),
            .commit_o (commit_o[g]),
            .err_o    (range_err_o[g])
        );

        uniform_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DW(VEC_W)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (mem_we),
            .widx  (mem_idx),
            .wvec  (mem_vec),
            .ridx  (rd_idx),
            .rdata (lane_rdata[g])
        );
    end

    assign rd_vec = lane_rdata[rd_lane];

endmodule

// File: tb/sim_uniform_assembler.sv
module sim_uniform_assembler;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [4:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic        rd_lane = 0;
    logic [6:0]  rd_idx = 0;
    logic [95:0] rd_vec;
    logic [1:0]  commit_o, range_err_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uniform_assembler u0 (.*);

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus write; returns the strobes seen right after the edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d, output logic [1:0] c, output logic [1:0] e);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        c = commit_o; e = range_err_o;
        bus_we = 0;
    endtask

    task automatic rd(input logic l, input logic [6:0] i, output logic [95:0] v);
        rd_lane = l; rd_idx = i; #1; v = rd_vec;
    endtask

    task automatic t_reset;
        logic [1:0] c, e; logic [95:0] v;
        check(commit_o == 0 && range_err_o == 0, "R13 strobes idle", {commit_o, range_err_o}, 0);
        wr(5'd8, 32'h11223344, c, e);  check(c == 0, "R2 no commit word1", c, 0);
        wr(5'd9, 32'h55667788, c, e);  check(c == 0, "R2 no commit word2", c, 0);
        wr(5'd15, 32'h99AABBCC, c, e); check(c == 2'b01, "R13 R2 packed commit word3", c, 2'b01);
        rd(0, 0, v);
        check(v == 96'h11223344_55667788_99AABBCC, "R3 packed layout idx0", v, 96'h11223344_55667788_99AABBCC);
    endtask

    task automatic t_float;
        logic [1:0] c, e; logic [95:0] v; logic [95:0] ex;
        wr(5'd0, 32'h8000_0005, c, e);
        wr(5'd9,  32'h3F800000, c, e); check(c == 0, "R1 no commit word1", c, 0);
        wr(5'd10, 32'h40000000, c, e); check(c == 0, "R1 no commit word2", c, 0);
        wr(5'd11, 32'hBFC00000, c, e); check(c == 0, "R1 no commit word3", c, 0);
        wr(5'd12, 32'h00000000, c, e); check(c == 2'b01, "R1 R10 commit word4", c, 2'b01);
        ex = {24'h3F0000, 24'h400000, 24'hBF8000, 24'h000000};
        rd(0, 5, v); check(v == ex, "R4 R5 reversed order and conversion", v, ex);
        wr(5'd13, 32'h0DA24260, c, e);
        wr(5'd14, 32'h8DA24260, c, e);
        wr(5'd8,  32'h7149F2CA, c, e);
        wr(5'd15, 32'hF149F2CA, c, e); check(c == 2'b01, "R9 second float commit", c, 2'b01);
        ex = {24'h000000, 24'h800000, 24'h7F0000, 24'hFF0000};
        rd(0, 6, v); check(v == ex, "R6 R9 zero flush and saturation at idx6", v, ex);
    endtask

    task automatic t_range;
        logic [1:0] c, e; logic [95:0] v;
        wr(5'd0, 32'd95, c, e);
        wr(5'd8, 32'hA0A0A0A0, c, e);
        wr(5'd8, 32'hB0B0B0B0, c, e);
        wr(5'd8, 32'hC0C0C0C0, c, e); check(c == 2'b01 && e == 0, "R8 last entry accepted", {c, e}, 4'b0100);
        wr(5'd8, 32'h1, c, e);
        wr(5'd8, 32'h2, c, e);        check(e == 0, "R7 no early error", e, 0);
        wr(5'd8, 32'h3, c, e);        check(c == 0 && e == 2'b01, "R8 out of range error", {c, e}, 4'b0001);
        rd(0, 95, v); check(v == 96'hA0A0A0A0_B0B0B0B0_C0C0C0C0, "R8 entry 95 untouched", v, 96'hA0A0A0A0_B0B0B0B0_C0C0C0C0);
        wr(5'd8, 32'h4, c, e);
        wr(5'd8, 32'h5, c, e);        check(e == 0 && c == 0, "R7 counter restarted", {c, e}, 0);
        wr(5'd8, 32'h6, c, e);        check(e == 2'b01, "R9 index held after reject", e, 2'b01);
    endtask

    task automatic t_discard;
        logic [1:0] c, e; logic [95:0] v;
        wr(5'd0, 32'd10, c, e);
        wr(5'd8, 32'hDEADDEAD, c, e);
        wr(5'd8, 32'hBEEFBEEF, c, e);
        wr(5'd0, 32'd10, c, e);
        wr(5'd8, 32'h01010101, c, e);
        wr(5'd8, 32'h02020202, c, e); check(c == 0, "R12 partial discarded", c, 0);
        wr(5'd8, 32'h03030303, c, e); check(c == 2'b01, "R12 commit after restart", c, 2'b01);
        rd(0, 10, v); check(v == 96'h01010101_02020202_03030303, "R12 new words stored", v, 96'h01010101_02020202_03030303);
    endtask

    task automatic t_lanes;
        logic [1:0] c, e; logic [95:0] v;
        wr(5'd0, 32'd20, c, e);
        wr(5'd8, 32'hAAAA0000, c, e);
        wr(5'd16, 32'd20, c, e);
        wr(5'd24, 32'h11111111, c, e);
        wr(5'd25, 32'h22222222, c, e);
        wr(5'd31, 32'h33333333, c, e); check(c == 2'b10, "R11 only lane1 commits", c, 2'b10);
        wr(5'd8, 32'hBBBB0000, c, e);
        wr(5'd8, 32'hCCCC0000, c, e); check(c == 2'b01, "R11 lane0 counter kept", c, 2'b01);
        rd(0, 20, v); check(v == 96'hAAAA0000_BBBB0000_CCCC0000, "R11 lane0 data", v, 96'hAAAA0000_BBBB0000_CCCC0000);
        rd(1, 20, v); check(v == 96'h11111111_22222222_33333333, "R11 lane1 data", v, 96'h11111111_22222222_33333333);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        t_reset();
        t_float();
        t_range();
        t_discard();
        t_lanes();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule